// File: doc/BRIEF.md
# Hardware Cursor Overlay Compositor

This block places a 32 by 32 pixel cursor image on top of a display pixel stream. On every clock it receives the raster coordinate of the pixel being scanned out and the background colour of that pixel in 15-bit RGB (5 bits per channel). When the coordinate falls inside the cursor window, the block looks up the matching cursor code in an on-chip bitmap. The code decides the output pixel. It can let the background through, replace it with an opaque colour, or invert every background bit. The composited pixel comes out one clock later.

The bitmap is loaded through a simple write port, one 16-bit code per write. Codes are stored row by row, 32 codes per row. The cursor position arrives as one 32-bit word. In immediate mode the new position takes effect on the next clock. In retrace-synchronised mode the word is held as a pending position and copied into the active position when vertical retrace starts. Moving the cursor therefore never tears it in the middle of a frame.

Top module: `cursor_overlay`

## Requirements
- R1: The cursor code 16'h0000 is transparent: the output equals the background pixel.
- R2: A code with bit 15 set is opaque: the output equals code bits 14:0. For example, 16'hFFFF gives 15'h7FFF (white) and 16'h8000 gives 15'h0000 (black).
- R3: A nonzero code with bit 15 clear (16'h7FFF included) inverts the pixel: the output equals background XOR 15'h7FFF.
- R4: A cursor code applies only when 0 <= raster_x - pos_x < 32 and 0 <= raster_y - pos_y < 32. It is read from bitmap entry (raster_x - pos_x) + 32*(raster_y - pos_y). Every other pixel passes the background through.
- R5: While cur_en is low for a pixel, that pixel passes the background through whatever the bitmap holds.
- R6: The position word carries x in bits 11:0 and y in bits 27:16. Bits 15:12 and 31:28 are ignored.
- R7: With sync_en high, a position write becomes pending and the old position stays in use until vretrace rises. The latest pending write is the one applied.
- R8: With sync_en high, a position write in the same cycle as the rising edge of vretrace takes effect at that edge and replaces any older pending position.
- R9: With sync_en low, a position write is used for pixels presented from the next cycle onward.
- R10: pix_out shows the result for the inputs presented one clock earlier.
- R11: A bitmap write to the entry being read in the same cycle returns the old code for that pixel. The new code is seen from the next cycle.
- R12: While rst is high, pix_out is 0. After reset the active position is (0,0) and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| raster_x | input | 12 | Horizontal coordinate of the current pixel |
| raster_y | input | 12 | Vertical coordinate of the current pixel |
| bg_pix | input | 15 | Background pixel, RGB 5:5:5 |
| cur_en | input | 1 | Cursor enable for this pixel |
| sync_en | input | 1 | 1: position updates wait for retrace start; 0: immediate |
| vretrace | input | 1 | Vertical retrace level; its rising edge marks retrace start |
| pos_wr | input | 1 | Position word write strobe |
| pos_data | input | 32 | Position word (x in 11:0, y in 27:16) |
| bmp_wr | input | 1 | Bitmap write strobe |
| bmp_addr | input | 10 | Bitmap entry index, x + 32*y |
| bmp_data | input | 16 | Cursor code to store |
| pix_out | output | 15 | Composited pixel, one clock after its inputs |

## Verification
Two pairs of events can meet in one cycle. A position write can land in the same cycle that vretrace rises, and a bitmap write can target the entry that the current pixel reads. The bench forces both collisions on purpose. It places the coincident position write on top of an older pending one, and it rewrites the bitmap entry under the raster in the cycle that entry is read. The expected pixel comes from a cycle-exact model that applies the old state first and the update after it. The new position or code must therefore appear exactly one pixel later, and never earlier.

// File: rtl/curs_ovl_pkg.sv
package curs_ovl_pkg;

    // Geometry and data widths of the compositor
    parameter int unsigned COORD_W   = 12;
    parameter int unsigned DIM_LOG2  = 5;
    parameter int unsigned PIX_W     = 15;
    parameter int unsigned CODE_W    = PIX_W + 1;
    parameter int unsigned POS_W     = 32;
    parameter int unsigned POS_Y_LSB = 16;

    localparam int unsigned CUR_DIM   = 1 << DIM_LOG2;
    localparam int unsigned BMP_AW    = 2 * DIM_LOG2;
    localparam int unsigned BMP_DEPTH = 1 << BMP_AW;

    typedef logic [PIX_W-1:0]   pix_t;
    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [BMP_AW-1:0]  bmp_idx_t;

    typedef struct packed {
        coord_t y;
        coord_t x;
    } cur_pos_t;

    typedef enum logic [1:0] {
        ACT_PASS   = 2'd0,
        ACT_OPAQUE = 2'd1,
        ACT_INVERT = 2'd2
    } pix_act_e;

    // Extract coordinates from a position word
    function automatic cur_pos_t unpack_pos(input logic [POS_W-1:0] w);
        cur_pos_t p;
        p.x = w[COORD_W-1:0];
        p.y = w[POS_Y_LSB +: COORD_W];
        return p;
    endfunction

    // Map a cursor code onto its pixel action
    function automatic pix_act_e classify(input code_t c);
        if (c[CODE_W-1])
            return ACT_OPAQUE;
        else if (c[PIX_W-1:0] != '0)
            return ACT_INVERT;
        return ACT_PASS;
    endfunction

    // Produce the final pixel from action, code and background
    function automatic pix_t compose(input pix_act_e a, input code_t c, input pix_t bg);
        case (a)
            ACT_OPAQUE: return c[PIX_W-1:0];
            ACT_INVERT: return bg ^ {PIX_W{1'b1}};
            default:    return bg;
        endcase
    endfunction

endpackage

// File: rtl/curs_pos_ctrl.sv
module curs_pos_ctrl
    import curs_ovl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sync_en,
    input  logic                 vretrace,
    input  logic                 pos_wr,
    input  logic [POS_W-1:0]     pos_data,
    output cur_pos_t             act_pos
);

    cur_pos_t wr_pos;
    cur_pos_t act_q;
    cur_pos_t pend_q;
    logic     pend_v_q;
    logic     vr_q;
    logic     retr_edge;

    assign wr_pos    = unpack_pos(pos_data);
    assign retr_edge = vretrace && !vr_q;
    assign act_pos   = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            vr_q     <= 1'b0;
        end else begin
            vr_q <= vretrace;
            if (!sync_en) begin
                if (pos_wr)
                    act_q <= wr_pos;
            end else if (retr_edge) begin
                if (pos_wr)
                    act_q <= wr_pos;
                else if (pend_v_q)
                    act_q <= pend_q;
                pend_v_q <= 1'b0;
            end else if (pos_wr) begin
                pend_q   <= wr_pos;
                pend_v_q <= 1'b1;
            end
        end
    end

    // R9: immediate mode takes the written word on the next edge
    p_imm_apply_r9: assert property (@(posedge clk) disable iff (rst)
        (!sync_en && pos_wr) |=> (act_q == $past(wr_pos)));

    // R7: synchronised mode holds the active copy between retrace starts
    p_hold_until_retrace_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_en && !retr_edge) |=> $stable(act_q));

    // R8: coincident write wins at retrace start
    p_coincident_write_r8: assert property (@(posedge clk) disable iff (rst)
        (sync_en && retr_edge && pos_wr) |=> (act_q == $past(wr_pos)));

    // R7: pending copy is consumed at retrace start
    p_pend_consumed_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_en && retr_edge) |=> !pend_v_q);

endmodule

// File: rtl/curs_hit_calc.sv
module curs_hit_calc
    import curs_ovl_pkg::*;
#(
    parameter int unsigned CW   = COORD_W,
    parameter int unsigned LOG2 = DIM_LOG2
) (
    input  logic [CW-1:0]     raster_x,
    input  logic [CW-1:0]     raster_y,
    input  logic [CW-1:0]     pos_x,
    input  logic [CW-1:0]     pos_y,
    output logic              hit,
    output logic [2*LOG2-1:0] idx
);

    localparam int unsigned DIM = 1 << LOG2;

    logic [1:0][CW-1:0]   rc;
    logic [1:0][CW-1:0]   pc;
    logic [1:0]           in_rng;
    logic [1:0][LOG2-1:0] off;

    assign rc[0] = raster_x;
    assign rc[1] = raster_y;
    assign pc[0] = pos_x;
    assign pc[1] = pos_y;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [CW:0] diff;
        assign diff      = {1'b0, rc[a]} - {1'b0, pc[a]};
        assign in_rng[a] = !diff[CW] && (diff[CW-1:0] < CW'(DIM));
        assign off[a]    = diff[LOG2-1:0];
    end

    assign hit = &in_rng;
    assign idx = {off[1], off[0]};

endmodule

// File: rtl/curs_bitmap_ram.sv
module curs_bitmap_ram #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Read-first: the registered read sees the pre-write contents
    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else
            rd_q <= mem[rd_addr];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import curs_ovl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [11:0]  raster_x,
    input  logic [11:0]  raster_y,
    input  logic [14:0]  bg_pix,
    input  logic         cur_en,
    input  logic         sync_en,
    input  logic         vretrace,
    input  logic         pos_wr,
    input  logic [31:0]  pos_data,
    input  logic         bmp_wr,
    input  logic [9:0]   bmp_addr,
    input  logic [15:0]  bmp_data,
    output logic [14:0]  pix_out
);

    cur_pos_t act_pos;
    logic     hit;
    bmp_idx_t rd_idx;
    code_t    code_q;
    logic     hit_q;
    logic     en_q;
    pix_t     bg_q;
    pix_act_e act;

    curs_pos_ctrl u_pos (
        .clk      (clk),
        .rst      (rst),
        .sync_en  (sync_en),
        .vretrace (vretrace),
        .pos_wr   (pos_wr),
        .pos_data (pos_data),
        .act_pos  (act_pos)
    );

    curs_hit_calc #(
        .CW   (COORD_W),
        .LOG2 (DIM_LOG2)
    ) u_hit (
        .raster_x (raster_x),
        .raster_y (raster_y),
        .pos_x    (act_pos.x),
        .pos_y    (act_pos.y),
        .hit      (hit),
        .idx      (rd_idx)
    );

    curs_bitmap_ram #(
        .AW (BMP_AW),
        .DW (CODE_W)
    ) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bmp_wr),
        .wr_addr (bmp_addr),
        .wr_data (bmp_data),
        .rd_addr (rd_idx),
        .rd_data (code_q)
    );

    // Align background and qualifiers with the bitmap read
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            en_q  <= 1'b0;
            bg_q  <= '0;
        end else begin
            hit_q <= hit;
            en_q  <= cur_en;
            bg_q  <= bg_pix;
        end
    end

    assign act     = (hit_q && en_q) ? classify(code_q) : ACT_PASS;
    assign pix_out = compose(act, code_q, bg_q);

    // R5: a disabled pixel shows its own background one clock later
    p_disabled_pass_r5: assert property (@(posedge clk) disable iff (rst)
        !cur_en |=> (pix_out == $past(bg_pix)));

    // R12: output is dark while reset holds
    p_reset_dark_r12: assert property (@(posedge clk)
        rst |=> (pix_out == '0));

    // R4: a pixel outside the window shows its own background
    p_outside_pass_r4: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (pix_out == $past(bg_pix)));

endmodule

// File: tb/cursor_overlay_tb_top.sv
module cursor_overlay_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] raster_x, raster_y;
    logic [14:0] bg_pix;
    logic        cur_en, sync_en, vretrace, pos_wr, bmp_wr;
    logic [31:0] pos_data;
    logic [9:0]  bmp_addr;
    logic [15:0] bmp_data;
    logic [14:0] pix_out;

    always #10 clk = ~clk;

    cursor_overlay dut_i (
        .clk(clk), .rst(rst), .raster_x(raster_x), .raster_y(raster_y),
        .bg_pix(bg_pix), .cur_en(cur_en), .sync_en(sync_en), .vretrace(vretrace),
        .pos_wr(pos_wr), .pos_data(pos_data), .bmp_wr(bmp_wr), .bmp_addr(bmp_addr),
        .bmp_data(bmp_data), .pix_out(pix_out)
    );

    // Reference state
    logic [15:0] m_mem [1024];
    int          m_px, m_py, m_qx, m_qy;
    bit          m_pend, m_vb;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    function automatic logic [14:0] model_out();
        int dx, dy;
        logic [15:0] c;
        dx = int'(raster_x) - m_px;
        dy = int'(raster_y) - m_py;
        if (!cur_en || dx < 0 || dx > 31 || dy < 0 || dy > 31) return bg_pix;
        c = m_mem[dx + 32 * dy];
        if (c == 16'h0000) return bg_pix;
        if (c[15]) return c[14:0];
        return bg_pix ^ 15'h7FFF;
    endfunction

    task automatic model_update();
        int nx, ny;
        bit edge_now;
        nx = int'(pos_data[11:0]);
        ny = int'(pos_data[27:16]);
        edge_now = vretrace && !m_vb;
        if (!sync_en) begin
            if (pos_wr) begin m_px = nx; m_py = ny; end
        end else if (edge_now) begin
            if (pos_wr) begin m_px = nx; m_py = ny; end
            else if (m_pend) begin m_px = m_qx; m_py = m_qy; end
            m_pend = 0;
        end else if (pos_wr) begin
            m_qx = nx; m_qy = ny; m_pend = 1;
        end
        m_vb = vretrace;
        if (bmp_wr) m_mem[bmp_addr] = bmp_data;
    endtask

    task automatic chk(input string req, input logic [14:0] exp);
        n_chk++;
        if (pix_out !== exp) begin
            n_fail++;
            $display("FAIL %s: pix_out=%h expected=%h", req, pix_out, exp);
        end
    endtask

    // One pixel: inputs already driven at the falling edge
    task automatic cyc(input string req, input bit do_chk);
        logic [14:0] exp;
        exp = model_out();
        model_update();
        @(posedge clk);
        #5;
        if (do_chk) chk(req, exp);
        @(negedge clk);
        pos_wr = 0;
        bmp_wr = 0;
    endtask

    task automatic px(input int x, input int y, input logic [14:0] bg);
        raster_x = 12'(x);
        raster_y = 12'(y);
        bg_pix   = bg;
    endtask

    task automatic wr_code(input int a, input logic [15:0] d);
        bmp_wr = 1; bmp_addr = 10'(a); bmp_data = d;
    endtask

    task automatic wr_pos(input int x, input int y, input logic [7:0] junk);
        pos_wr = 1;
        pos_data = {junk[7:4], 12'(y), junk[3:0], 12'(x)};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: pix_out=%h expected=completion", pix_out);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; raster_x = 0; raster_y = 0; bg_pix = 15'h1555; cur_en = 1;
        sync_en = 0; vretrace = 0; pos_wr = 0; pos_data = 0;
        bmp_wr = 0; bmp_addr = 0; bmp_data = 0;
        m_px = 0; m_py = 0; m_qx = 0; m_qy = 0; m_pend = 0; m_vb = 0;
        repeat (3) @(posedge clk);
        #5;
        chk("R12 reset output", 15'h0000);
        @(negedge clk);
        rst = 0;

        // Load the bitmap with the raster far outside the window
        for (int i = 0; i < 1024; i++) begin
            logic [15:0] d;
            case (i)
                0: d = 16'h0000;
                1: d = 16'hFFFF;
                2: d = 16'h8000;
                3: d = 16'h7FFF;
                4: d = 16'h1234;
                5: d = 16'h9ABC;
                31: d = 16'h8001;
                992: d = 16'h8002;
                1023: d = 16'h8003;
                default: d = 16'($urandom());
            endcase
            px(3000, 3000, 15'($urandom()));
            wr_code(i, d);
            cyc("R4 outside window during load", (i % 64) == 0);
        end

        // R12: active position is (0,0) after reset
        px(1, 0, 15'h0123); cyc("R12 position zero after reset", 1);

        // Move cursor to (100,50) immediately
        px(500, 500, 15'h0000); wr_pos(100, 50, 8'h00); cyc("R9 write", 1);
        px(100, 50, 15'h2AAA); cyc("R1 transparent", 1);
        px(101, 50, 15'h2AAA); cyc("R2 white", 1);
        px(102, 50, 15'h2AAA); cyc("R2 black", 1);
        px(103, 50, 15'h2AAA); cyc("R3 invert 7FFF", 1);
        px(104, 50, 15'h0F0F); cyc("R3 invert other code", 1);
        px(105, 50, 15'h0F0F); cyc("R2 opaque colour", 1);
        // R10: output follows each new pixel one clock later
        px(103, 50, 15'h0001); cyc("R10 latency a", 1);
        px(103, 50, 15'h7000); cyc("R10 latency b", 1);

        // R4 window edges
        px(99, 50, 15'h1111);  cyc("R4 left of window", 1);
        px(131, 50, 15'h1111); cyc("R4 right column", 1);
        px(132, 50, 15'h1111); cyc("R4 past right", 1);
        px(100, 49, 15'h1111); cyc("R4 above window", 1);
        px(100, 81, 15'h1111); cyc("R4 bottom row", 1);
        px(131, 81, 15'h1111); cyc("R4 last entry", 1);
        px(100, 82, 15'h1111); cyc("R4 below window", 1);

        // R5: disabled cursor
        cur_en = 0;
        px(101, 50, 15'h0C0C); cyc("R5 disabled", 1);
        px(103, 50, 15'h0C0C); cyc("R5 disabled invert", 1);
        cur_en = 1;

        // R6: junk in ignored bits
        px(500, 500, 15'h0); wr_pos(70, 60, 8'hFA); cyc("R6 write", 1);
        px(71, 60, 15'h0333); cyc("R6 field decode", 1);
        px(70, 60, 15'h0333); cyc("R6 field decode origin", 1);

        // R9: write and pixel at new location in same cycle use old position
        px(201, 10, 15'h0444); wr_pos(200, 10, 8'h00); cyc("R9 same cycle old", 1);
        px(201, 10, 15'h0444); cyc("R9 next cycle new", 1);

        // R7: synchronised update
        sync_en = 1;
        px(301, 20, 15'h0555); wr_pos(400, 400, 8'h00); cyc("R7 pending write", 1);
        px(301, 20, 15'h0555); wr_pos(300, 20, 8'h00); cyc("R7 second pending", 1);
        px(301, 20, 15'h0555); cyc("R7 old position kept", 1);
        px(201, 10, 15'h0555); cyc("R7 old position active", 1);
        vretrace = 1;
        px(301, 20, 15'h0555); cyc("R7 retrace edge cycle", 1);
        px(301, 20, 15'h0555); cyc("R7 latest pending applied", 1);
        px(401, 400, 15'h0555); cyc("R7 earlier pending dropped", 1);
        // level high does not reapply
        px(500, 500, 15'h0); wr_pos(600, 600, 8'h00); cyc("R7 write during retrace", 1);
        px(301, 20, 15'h0666); cyc("R7 level does not apply", 1);
        vretrace = 0;
        px(301, 20, 15'h0666); cyc("R7 still old", 1);

        // R8: write coincides with retrace start, overriding pending (600,600)
        vretrace = 1;
        px(801, 5, 15'h0777); wr_pos(800, 5, 8'h00); cyc("R8 coincident cycle", 1);
        px(801, 5, 15'h0777); cyc("R8 coincident applied", 1);
        px(601, 600, 15'h0777); cyc("R8 older pending dropped", 1);
        vretrace = 0;
        px(801, 5, 15'h0777); cyc("R8 stays", 1);
        sync_en = 0;

        // R11: write the entry being read
        px(801, 5, 15'h0888); wr_code(1, 16'h8123); cyc("R11 old code on collision", 1);
        px(801, 5, 15'h0888); cyc("R11 new code next cycle", 1);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int bx, by;
            bx = m_px; by = m_py;
            cur_en   = ($urandom_range(0, 9) != 0);
            sync_en  = ($urandom_range(0, 3) == 0);
            vretrace = ($urandom_range(0, 7) == 0);
            px(bx + $urandom_range(0, 40) - 4, by + $urandom_range(0, 40) - 4, 15'($urandom()));
            if ($urandom_range(0, 30) == 0)
                wr_pos($urandom_range(0, 400), $urandom_range(0, 400), 8'($urandom()));
            if ($urandom_range(0, 5) == 0) begin
                logic [15:0] d;
                case ($urandom_range(0, 4))
                    0: d = 16'h0000;
                    1: d = 16'hFFFF;
                    2: d = 16'h8000;
                    3: d = 16'h7FFF;
                    default: d = 16'($urandom());
                endcase
                wr_code($urandom_range(0, 1023), d);
            end
            cyc("R4 R10 random pixel", 1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule